// File: doc/BRIEF.md
# Serial Sampling-Converter Interface Emulator

This block reproduces the digital behaviour of a three-wire serial sampling converter so that a host controller can be tested against it without an analog part. A parallel sample word stands in for the conversion result. The host pulls an active-low chip select low to open a frame and then toggles a serial clock. The block shifts out a 16-clock word: four leading zeros, the result in straight binary with the most significant bit first, and trailing zeros that fill the word to 16 bits. The serial data line is modelled as a data bit plus an output enable, so the enable low stands for high impedance.

Chip select and serial clock are asynchronous to the fast system clock. Each passes through a two-flop synchronizer and an edge detector. The count of serial-clock falling edges seen when chip select returns high decides the power mode (normal, shutdown or powering up). The block flags frames whose data is a dummy (the first frame after reset and every wake-up frame), drives a track/hold indicator and reports whether the most recently finished frame carried a valid result. The result width is a parameter of 12, 10 or 8 bits.

The serial interface carries no handshake: the host owns the timing, so there is no valid/ready and no back-pressure. The sample word is taken once per frame, at the start of the frame, and is free to change afterwards.

Top module: `adc_serial_emu`

## Requirements
- R1: A falling chip select starts a frame. The output enable rises, hold rises, and the sample word present in that cycle is captured. Later changes of the sample input do not alter the frame.
- R2: The 16-bit frame word is four zeros, then the WIDTH-bit sample in straight binary, MSB first, then 12-WIDTH zeros (none at 12, two at 10, four at 8).
- R3: Frame bit 15 is driven from the start of the frame. After the k-th serial-clock falling edge of the frame (k from 1 to 15), bit 15-k is driven, so at 12 bits the LSB is valid at the 16th falling edge. This holds whether the serial clock idles high or low.
- R4: The output enable drops after the 16th falling edge or at the rising chip select, whichever comes first. Further falling edges in that frame are ignored, and sdata reads 0 while the enable is low.
- R5: hold stays high from the frame start until the 13th serial-clock rising edge of the frame, or until chip select rises if that comes earlier.
- R6: If chip select rises with fewer than 2 falling edges in the frame, a normal-mode block keeps its mode. The mode changes only on frame start, on a counted falling edge, or on chip select rising inside a frame.
- R7: If chip select rises with 2 to 9 falling edges in the frame, a normal-mode block enters shutdown.
- R8: If chip select rises with 10 to 15 falling edges in the frame, the word is cut short and the mode stays normal.
- R9: A frame that starts outside normal mode enters powering-up and is flagged dummy. On its 10th falling edge the block becomes normal; a chip-select rise before that edge returns it to shutdown. Normal is never entered directly from shutdown.
- R10: After reset the mode reads unknown, and the first frame is treated as a dummy.
- R11: last_valid is set at the 16th falling edge when the frame was not a dummy. It is cleared at the 16th falling edge of a dummy frame and by any frame that chip select ends early.
- R12: A pin change takes effect on the third rising edge of clk after it; the registered outputs change in the cycle that follows that edge.
- R13: mode encoding: 2'b00 unknown, 2'b01 normal, 2'b10 shutdown, 2'b11 powering up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select from the host, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sample | input | WIDTH | Stand-in conversion result, captured at frame start |
| sdata | output | 1 | Serial data bit, 0 when not enabled |
| sdata_oe | output | 1 | Drive enable for sdata; low means high impedance |
| hold | output | 1 | High while the emulated track/hold is holding |
| frame_dummy | output | 1 | High during a frame whose data is not valid |
| mode | output | 2 | Power mode, encoded as in R13 |
| last_valid | output | 1 | Last finished frame delivered a valid result |

## Verification
The bench builds three instances side by side, with WIDTH set to 12, 10 and 8, and drives all three with the same chip-select and serial-clock waveforms. This covers the frame-word variant with no trailing padding as well as the two padded layouts. It also shows that the mode rules do not depend on width. The falling-edge counts at which chip select is raised are chosen at the rule boundaries: 1, 2, 9, 10, 12, 16 and 18. One frame runs with the serial clock idling high.

// File: rtl/adcemu_pkg.sv
package adcemu_pkg;

  localparam int FRAME_BITS    = 16;
  localparam int LEAD_BITS     = 4;
  localparam int ABANDON_EDGES = 2;
  localparam int COMMIT_EDGES  = 10;
  localparam int TRACK_EDGES   = 13;

  typedef enum logic [1:0] {
    MODE_UNKNOWN  = 2'b00,
    MODE_NORMAL   = 2'b01,
    MODE_SHUTDOWN = 2'b10,
    MODE_POWERUP  = 2'b11
  } pwr_mode_e;

endpackage

// File: rtl/adcemu_sync.sv
module adcemu_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], async_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise_o = chain[STAGES-1] & ~prev;
  assign fall_o = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/adcemu_frame.sv
module adcemu_frame #(
  parameter int WIDTH       = 12,
  parameter int FRAME_BITS  = 16,
  parameter int LEAD_BITS   = 4,
  parameter int TRACK_EDGES = 13,
  parameter int CW          = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sck_fall,
  input  logic             sck_rise,
  input  logic [WIDTH-1:0] sample,
  output logic             sdata_o,
  output logic             oe_o,
  output logic             hold_o,
  output logic             start_o,
  output logic             cut_o,
  output logic             adv_o,
  output logic             done_o,
  output logic [CW-1:0]    falls_o
);

  localparam int TRAIL_BITS = FRAME_BITS - LEAD_BITS - WIDTH;
  localparam int RW         = $clog2(TRACK_EDGES + 1);
  localparam logic [CW-1:0] LAST_FALL = CW'(FRAME_BITS - 1);
  localparam logic [RW-1:0] LAST_RISE = RW'(TRACK_EDGES - 1);

  logic [FRAME_BITS-1:0] word;
  logic [FRAME_BITS-1:0] shreg;
  logic [CW-1:0]         fcnt;
  logic [RW-1:0]         rcnt;
  logic                  active;
  logic                  holding;

  if (TRAIL_BITS == 0) begin : g_notrail
    assign word = {{LEAD_BITS{1'b0}}, sample};
  end else begin : g_trail
    assign word = {{LEAD_BITS{1'b0}}, sample, {TRAIL_BITS{1'b0}}};
  end

  assign start_o = cs_fall;
  assign cut_o   = active & cs_rise;
  assign adv_o   = active & sck_fall & ~cs_rise;
  assign done_o  = adv_o & (fcnt == LAST_FALL);
  assign falls_o = fcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      holding <= 1'b0;
      fcnt    <= '0;
      rcnt    <= '0;
      shreg   <= '0;
    end else if (cs_fall) begin
      active  <= 1'b1;
      holding <= 1'b1;
      fcnt    <= '0;
      rcnt    <= '0;
      shreg   <= word;
    end else if (cut_o) begin
      active  <= 1'b0;
      holding <= 1'b0;
    end else begin
      if (adv_o) begin
        fcnt  <= fcnt + 1'b1;
        shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
        if (done_o) active <= 1'b0;
      end
      if (active && sck_rise && holding) begin
        rcnt <= rcnt + 1'b1;
        if (rcnt == LAST_RISE) holding <= 1'b0;
      end
    end
  end

  assign oe_o    = active;
  assign hold_o  = holding;
  assign sdata_o = active & shreg[FRAME_BITS-1];

  AST_OE_OPENS_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> $past(cs_fall)); // R1
  AST_OE_SHUT_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_rise) |-> !oe_o); // R4
  AST_HOLD_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> oe_o); // R5
  AST_LEAD_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && fcnt < CW'(LEAD_BITS)) |-> !sdata_o); // R2

endmodule

// File: rtl/adcemu_mode.sv
module adcemu_mode
  import adcemu_pkg::*;
#(
  parameter int ABANDON_EDGES = 2,
  parameter int COMMIT_EDGES  = 10,
  parameter int CW            = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cut,
  input  logic          adv,
  input  logic          done,
  input  logic [CW-1:0] falls,
  output pwr_mode_e     mode_o,
  output logic          dummy_o,
  output logic          last_valid_o
);

  localparam logic [CW-1:0] ABN = CW'(ABANDON_EDGES);
  localparam logic [CW-1:0] CMT = CW'(COMMIT_EDGES);
  localparam logic [CW-1:0] PRE = CW'(COMMIT_EDGES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o       <= MODE_UNKNOWN;
      dummy_o      <= 1'b0;
      last_valid_o <= 1'b0;
    end else if (start) begin
      if (mode_o != MODE_NORMAL) begin
        mode_o  <= MODE_POWERUP;
        dummy_o <= 1'b1;
      end else begin
        dummy_o <= 1'b0;
      end
    end else if (cut) begin
      last_valid_o <= 1'b0;
      dummy_o      <= 1'b0;
      if (mode_o == MODE_POWERUP)
        mode_o <= MODE_SHUTDOWN;
      else if (mode_o == MODE_NORMAL && falls >= ABN && falls < CMT)
        mode_o <= MODE_SHUTDOWN;
    end else begin
      if (adv && falls == PRE && mode_o == MODE_POWERUP)
        mode_o <= MODE_NORMAL;
      if (done) begin
        last_valid_o <= !dummy_o;
        dummy_o      <= 1'b0;
      end
    end
  end

  AST_NO_DIRECT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_o == MODE_SHUTDOWN) |-> mode_o != MODE_NORMAL); // R9
  AST_VALID_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last_valid_o) |-> $past(done && !dummy_o)); // R11
  AST_MODE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != $past(mode_o)) |-> $past(start || cut || adv)); // R6
  AST_UNKNOWN_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_o != MODE_UNKNOWN) |-> mode_o != MODE_UNKNOWN); // R10

endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
  import adcemu_pkg::*;
#(
  parameter int WIDTH         = 12,
  parameter int SYNC_STAGES   = 2,
  parameter int FRAME_LEN     = FRAME_BITS,
  parameter int LEAD_ZEROS    = LEAD_BITS,
  parameter int ABANDON_FALLS = ABANDON_EDGES,
  parameter int COMMIT_FALLS  = COMMIT_EDGES,
  parameter int TRACK_RISES   = TRACK_EDGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [WIDTH-1:0] sample,
  output logic             sdata,
  output logic             sdata_oe,
  output logic             hold,
  output logic             frame_dummy,
  output logic [1:0]       mode,
  output logic             last_valid
);

  localparam int CW = $clog2(FRAME_LEN + 1);

  logic          cs_rise, cs_fall, sck_rise, sck_fall;
  logic          start, cut, adv, done;
  logic [CW-1:0] falls;
  pwr_mode_e     mode_q;

  adcemu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .async_i(cs_n),
    .rise_o(cs_rise), .fall_o(cs_fall)
  );

  adcemu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sclk),
    .rise_o(sck_rise), .fall_o(sck_fall)
  );

  adcemu_frame #(
    .WIDTH(WIDTH), .FRAME_BITS(FRAME_LEN), .LEAD_BITS(LEAD_ZEROS),
    .TRACK_EDGES(TRACK_RISES), .CW(CW)
  ) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_fall(sck_fall), .sck_rise(sck_rise),
    .sample(sample),
    .sdata_o(sdata), .oe_o(sdata_oe), .hold_o(hold),
    .start_o(start), .cut_o(cut), .adv_o(adv), .done_o(done),
    .falls_o(falls)
  );

  adcemu_mode #(
    .ABANDON_EDGES(ABANDON_FALLS), .COMMIT_EDGES(COMMIT_FALLS), .CW(CW)
  ) u_mode (
    .clk(clk), .rst_n(rst_n),
    .start(start), .cut(cut), .adv(adv), .done(done), .falls(falls),
    .mode_o(mode_q), .dummy_o(frame_dummy), .last_valid_o(last_valid)
  );

  assign mode = mode_q;

endmodule

// File: tb/adc_serial_emu_bench.sv
module adc_serial_emu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic [11:0] smp = '0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          run_done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic int frame_bit(logic [11:0] v, int w, int idx);
    if (idx >= 12 - w && idx <= 11) return int'(v[idx - (12 - w)]);
    return 0;
  endfunction

  task automatic check(string tag, int w, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s width=%0d actual=%0d expected=%0d t=%0t", tag, w, act, exp, $time);
    end
  endtask

  for (genvar g = 0; g < 3; g++) begin : lane
    localparam int W = 12 - 2 * g;
    logic sd, oe, hd, dm, lv;
    logic [1:0] md;
    int q_cs[3];
    int q_sk[3];
    int m_act, m_n, m_r, m_hold, m_dummy, m_mode, m_lv;
    logic [11:0] m_word;

    adc_serial_emu #(.WIDTH(W)) u_adc_serial_emu (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
      .sample(smp[W-1:0]),
      .sdata(sd), .sdata_oe(oe), .hold(hd), .frame_dummy(dm),
      .mode(md), .last_valid(lv)
    );

    always @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < 3; i++) begin q_cs[i] = 1; q_sk[i] = 0; end
        m_act = 0; m_n = 0; m_r = 0; m_hold = 0; m_dummy = 0; m_mode = 0; m_lv = 0;
        m_word = '0;
      end else begin
        bit cf, cr, kf, kr;
        cf = (q_cs[2] == 1) && (q_cs[1] == 0);
        cr = (q_cs[2] == 0) && (q_cs[1] == 1);
        kf = (q_sk[2] == 1) && (q_sk[1] == 0);
        kr = (q_sk[2] == 0) && (q_sk[1] == 1);
        if (cf) begin
          m_act = 1; m_n = 0; m_r = 0; m_hold = 1;
          m_word = smp & 12'((1 << W) - 1);
          if (m_mode != 1) begin m_mode = 3; m_dummy = 1; end
          else m_dummy = 0;
        end else if (cr && m_act == 1) begin
          if (m_mode == 3) m_mode = 2;
          else if (m_mode == 1 && m_n >= 2 && m_n < 10) m_mode = 2;
          m_act = 0; m_hold = 0; m_lv = 0; m_dummy = 0;
        end else if (m_act == 1 && kf) begin
          m_n++;
          if (m_n == 10 && m_mode == 3) m_mode = 1;
          if (m_n == 16) begin m_act = 0; m_lv = (m_dummy == 0); m_dummy = 0; end
        end else if (m_act == 1 && kr && m_hold == 1) begin
          m_r++;
          if (m_r == 13) m_hold = 0;
        end
        q_cs[2] = q_cs[1]; q_cs[1] = q_cs[0]; q_cs[0] = int'(cs_n);
        q_sk[2] = q_sk[1]; q_sk[1] = q_sk[0]; q_sk[0] = int'(sclk);
      end
    end

    always @(negedge clk) begin
      if (rst_n) begin
        check("R4", W, int'(oe), m_act);
        if (m_act == 1) check("R2", W, int'(sd), frame_bit(m_word, W, 15 - m_n));
        else check("R4", W, int'(sd), 0);
        check("R5", W, int'(hd), m_hold);
        check("R9", W, int'(dm), m_dummy);
        check("R6", W, int'(md), m_mode);
        check("R11", W, int'(lv), m_lv);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_mode(string tag, int exp);
    check(tag, 12, int'(lane[0].md), exp);
    check(tag, 10, int'(lane[1].md), exp);
    check(tag, 8,  int'(lane[2].md), exp);
  endtask

  task automatic check_lv(string tag, int exp);
    check(tag, 12, int'(lane[0].lv), exp);
    check(tag, 10, int'(lane[1].lv), exp);
    check(tag, 8,  int'(lane[2].lv), exp);
  endtask

  task automatic run_frame(input logic [11:0] v, input int falls, input bit idle_hi, input bit wake);
    smp = v; sclk = idle_hi; tick(6);
    cs_n = 1'b0;
    tick(2);
    check("R12", 12, int'(lane[0].oe), 0);
    tick(1);
    check("R1", 12, int'(lane[0].oe), 1);
    check("R5", 12, int'(lane[0].hd), 1);
    check("R3", 12, int'(lane[0].sd), 0);
    if (wake) begin
      check("R9", 12, int'(lane[0].md), 3);
      check("R9", 12, int'(lane[0].dm), 1);
    end
    tick(1);
    smp = ~v;
    for (int k = 1; k <= falls; k++) begin
      if (!idle_hi) begin
        sclk = 1'b1; tick(3); sclk = 1'b0; tick(3);
      end else begin
        sclk = 1'b0; tick(3);
      end
      if (k < 16) check("R3", 12, int'(lane[0].sd), frame_bit(v, 12, 15 - k));
      else check("R4", 12, int'(lane[0].oe), 0);
      if (idle_hi) begin sclk = 1'b1; tick(3); end
    end
    tick(3);
    cs_n = 1'b1;
    tick(6);
    sclk = 1'b0;
    tick(6);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(2);
    check_mode("R10", 0);
    check_lv("R10", 0);
    check("R10", 12, int'(lane[0].oe), 0);

    run_frame(12'hA5C, 16, 1'b0, 1'b1);
    check_mode("R10", 1);  check_lv("R10", 0);
    run_frame(12'h3F1, 16, 1'b0, 1'b0);
    check_mode("R11", 1);  check_lv("R11", 1);
    run_frame(12'h7E2, 12, 1'b0, 1'b0);
    check_mode("R8", 1);   check_lv("R8", 0);
    run_frame(12'h111, 1, 1'b0, 1'b0);
    check_mode("R6", 1);
    run_frame(12'hFFF, 16, 1'b1, 1'b0);
    check_mode("R3", 1);   check_lv("R3", 1);
    run_frame(12'h924, 5, 1'b0, 1'b0);
    check_mode("R7", 2);
    run_frame(12'h0F0, 1, 1'b0, 1'b1);
    check_mode("R9", 2);
    run_frame(12'hB6D, 12, 1'b0, 1'b1);
    check_mode("R9", 1);   check_lv("R9", 0);
    run_frame(12'h001, 18, 1'b0, 1'b0);
    check_mode("R4", 1);   check_lv("R4", 1);
    run_frame(12'h555, 9, 1'b0, 1'b0);
    check_mode("R7", 2);
    run_frame(12'h800, 16, 1'b0, 1'b1);
    check_mode("R9", 1);   check_lv("R11", 0);
    run_frame(12'hABC, 10, 1'b0, 1'b0);
    check_mode("R8", 1);   check_lv("R8", 0);
    run_frame(12'h246, 2, 1'b0, 1'b0);
    check_mode("R7", 2);
    run_frame(12'hC3A, 16, 1'b0, 1'b1);
    run_frame(12'h5A5, 16, 1'b0, 1'b0);
    check_mode("R13", 1);  check_lv("R11", 1);

    run_done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!run_done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired before the run ended");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule